// File: doc/BRIEF.md
# Reduction-Tree Merge Node

This block is one stage of a many-to-one network that carries packets from processor cores to a single cache bank. Since every packet leaving the node goes to the same place, the node does no routing. It merges two incoming streams onto one outgoing link. The first stream is the local core's injection port. The second is the upstream network port, which carries traffic already merged by nodes further from the bank.

Each input keeps two small virtual-channel FIFOs, one per message class: requests and responses. A single fixed-priority arbiter chooses one flit per cycle from the four FIFOs. It ranks responses above requests, and within a class it ranks network traffic above local traffic. A FIFO can compete only when the next node has buffer room for that class. The node tracks that room with one credit counter per downstream class. Each time a FIFO hands over a flit, the node returns one credit to the sender that filled that FIFO.

Multi-flit packets are never interleaved. After a packet's first flit wins, its FIFO keeps the output until the tail flit has left.

Top module: `rtn_merge_node`

## Requirements
- R1: After reset, `out_vld`, `loc_crd_ret` and `net_crd_ret` are low, and each downstream class holds `DOWN_DEPTH` (default 4) credits. This means four flits of one class can leave before any credit comes back.
- R2: An incoming flit is queued by its class bit (0 = request, 1 = response). It leaves with the same class, payload and tail bit.
- R3: A flit arriving at an idle node with credits available is sampled at one clock edge. It appears on `out_vld`/`out_data` after the next edge: one cycle per hop.
- R4: When several FIFOs are eligible, the winner follows this order, highest first: network response, local response, network request, local request.
- R5: A class with zero downstream credits sends nothing. The other class still proceeds.
- R6: A credit pulse on `out_crd_in[c]` adds one credit to class c, and each flit sent removes one. Sending resumes one cycle after credits return.
- R7: In the same cycle a flit appears on the output, exactly one credit-return bit is high. It is on the port the flit came in on, at bit index equal to its class.
- R8: Once a non-tail flit is sent, no flit from any other FIFO is sent until that packet's tail flit (`tail` = 1) has left. This holds even when higher-priority traffic is waiting.
- R9: When no FIFO is both non-empty and backed by a credit, `out_vld` is low.
- R10: Each virtual-channel FIFO holds 4 flits and delivers them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_vld | input | 1 | Local port flit valid |
| loc_cls | input | 1 | Local flit class, 0 request / 1 response |
| loc_tail | input | 1 | Local flit is the last of its packet |
| loc_data | input | DATA_W | Local flit payload |
| loc_crd_ret | output | 2 | Credit returned to local sender, one bit per class |
| net_vld | input | 1 | Network port flit valid |
| net_cls | input | 1 | Network flit class |
| net_tail | input | 1 | Network flit is the last of its packet |
| net_data | input | DATA_W | Network flit payload |
| net_crd_ret | output | 2 | Credit returned to upstream node, one bit per class |
| out_vld | output | 1 | Output flit valid |
| out_cls | output | 1 | Output flit class |
| out_tail | output | 1 | Output flit is a tail |
| out_data | output | DATA_W | Output flit payload |
| out_crd_in | input | 2 | Credit returned by the downstream node, one bit per class |

## Verification
The assertions assume the two senders never push into a full FIFO. They also assume the downstream node never returns more credits than the node has spent, and that a packet keeps one class from head to tail. The stimulus honours all three. No test queues more than four flits in one FIFO. In automatic mode, credits return only for flits seen on the output. In the starvation test, credits are handed back one per edge, and only after the counter has been drained by exactly the flits the bench observed leaving.

// File: rtl/rtn_pkg.sv
// Package rtn_pkg
// Shared constants for the reduction-tree merge node.
// VC index = {class is request, port is local}. Index order is also the
// arbitration order, lowest index winning.
package rtn_pkg;
    localparam int NUM_VC  = 4;
    localparam int NUM_CLS = 2;

    typedef enum logic [1:0] {
        VC_NET_RSP = 2'd0,
        VC_LOC_RSP = 2'd1,
        VC_NET_REQ = 2'd2,
        VC_LOC_REQ = 2'd3
    } vc_e;

    // Message class carried by a VC index.
    function automatic logic vc_class(input int idx);
        return (idx < 2);
    endfunction

    // Port a VC index belongs to: 1 = local, 0 = network.
    function automatic logic vc_is_loc(input int idx);
        return (idx % 2) == 1;
    endfunction

    // VC index for a class and port.
    function automatic int vc_index(input int cls, input bit is_loc);
        return 2 * (1 - cls) + (is_loc ? 1 : 0);
    endfunction
endpackage

// File: rtl/rtn_vc_fifo.sv
// Module rtn_vc_fifo
// One virtual-channel buffer: a circular FIFO of DEPTH entries.
// Assumes the sender obeys credits, so it never pushes when full. Pop is
// requested only when non-empty.
module rtn_vc_fifo #(
    parameter int W     = 129,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_ent,
    input  logic         pop,
    output logic [W-1:0] head_ent,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign head_ent = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ent;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rtn_credit_ctr.sv
// Module rtn_credit_ctr
// Counts free slots in one downstream VC. Starts at DEPTH, drops on each
// flit sent, rises on each credit returned.
// Assumes the downstream never returns more credits than were spent.
module rtn_credit_ctr #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spend,
    input  logic refund,
    output logic avail
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;

    assign avail = (cnt != '0);

    // Credit balance update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(DEPTH);
        end else begin
            case ({spend, refund})
                2'b10:   cnt <= cnt - CNT_W'(1);
                2'b01:   cnt <= cnt + CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_credit_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    assert_spend_needs_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spend |-> cnt != '0);
endmodule

// File: rtl/rtn_prio_arb.sv
// Module rtn_prio_arb
// Fixed-priority N:1 arbiter with packet lock. Index 0 is highest priority.
// After a grant to a non-tail flit, only that index may win until its tail is
// granted. Requests already include the credit check.
module rtn_prio_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         tail,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IDX_W = $clog2(N);

    logic             locked;
    logic [IDX_W-1:0] lock_idx;

    // Pick the winner: locked owner only, else the lowest requesting index.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        if (locked) begin
            if (req[lock_idx]) begin
                gnt[lock_idx] = 1'b1;
                gnt_idx       = lock_idx;
                gnt_any       = 1'b1;
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) begin
                    gnt     = '0;
                    gnt[i]  = 1'b1;
                    gnt_idx = IDX_W'(i);
                    gnt_any = 1'b1;
                end
            end
        end
    end

    // Hold ownership from a head flit until its tail flit is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            lock_idx <= '0;
        end else if (gnt_any) begin
            locked   <= !tail[gnt_idx];
            lock_idx <= gnt_idx;
        end
    end

    assert_gnt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_gnt_backed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    assert_top_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && req[0]) |-> gnt[0]);
endmodule

// File: rtl/rtn_merge_node.sv
// Module rtn_merge_node
// Two-input, one-output merge node of a reduction tree. The local and network
// ports each feed two class FIFOs. One fixed-priority arbiter, gated by
// downstream credits, drives a registered output. Each dequeue returns a
// credit to the port it came from.
// Assumes senders obey returned credits and each packet keeps one class.
module rtn_merge_node
    import rtn_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int FIFO_DEPTH = 4,
    parameter int DOWN_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_vld,
    input  logic              loc_cls,
    input  logic              loc_tail,
    input  logic [DATA_W-1:0] loc_data,
    output logic [1:0]        loc_crd_ret,
    input  logic              net_vld,
    input  logic              net_cls,
    input  logic              net_tail,
    input  logic [DATA_W-1:0] net_data,
    output logic [1:0]        net_crd_ret,
    output logic              out_vld,
    output logic              out_cls,
    output logic              out_tail,
    output logic [DATA_W-1:0] out_data,
    input  logic [1:0]        out_crd_in
);
    localparam int ENT_W = DATA_W + 1;
    localparam int IDX_W = $clog2(NUM_VC);

    logic [ENT_W-1:0]   head_ent [NUM_VC];
    logic [NUM_VC-1:0]  push, empty, req, tails, gnt;
    logic [NUM_CLS-1:0] has_crd, spend;
    logic [IDX_W-1:0]   gnt_idx;
    logic               gnt_any;
    logic               gnt_cls;

    genvar v;
    generate
        for (v = 0; v < NUM_VC; v++) begin : g_vc
            localparam logic VC_CLS = vc_class(v);
            localparam logic IS_LOC = vc_is_loc(v);
            logic [ENT_W-1:0] in_ent;

            // Steer the arriving flit into the FIFO for its port and class.
            always_comb begin
                if (IS_LOC) begin
                    push[v] = loc_vld && (loc_cls == VC_CLS);
                    in_ent  = {loc_tail, loc_data};
                end else begin
                    push[v] = net_vld && (net_cls == VC_CLS);
                    in_ent  = {net_tail, net_data};
                end
            end

            rtn_vc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (push[v]),
                .push_ent (in_ent),
                .pop      (gnt[v]),
                .head_ent (head_ent[v]),
                .empty    (empty[v])
            );

            assign req[v]   = !empty[v] && has_crd[VC_CLS];
            assign tails[v] = head_ent[v][ENT_W-1];
        end

        for (v = 0; v < NUM_CLS; v++) begin : g_crd
            assign spend[v] = gnt_any && (gnt_cls == v[0]);
            rtn_credit_ctr #(.DEPTH(DOWN_DEPTH)) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .spend  (spend[v]),
                .refund (out_crd_in[v]),
                .avail  (has_crd[v])
            );
        end
    endgenerate

    rtn_prio_arb #(.N(NUM_VC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .tail    (tails),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign gnt_cls = !gnt_idx[1];

    // Output link register: one flit per cycle toward the next node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_cls  <= 1'b0;
            out_tail <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= gnt_any;
            if (gnt_any) begin
                out_cls  <= gnt_cls;
                out_tail <= head_ent[gnt_idx][ENT_W-1];
                out_data <= head_ent[gnt_idx][DATA_W-1:0];
            end
        end
    end

    // Credit return pulses to each sender, one bit per class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_crd_ret <= '0;
            net_crd_ret <= '0;
        end else begin
            for (int c = 0; c < NUM_CLS; c++) begin
                loc_crd_ret[c] <= gnt[vc_index(c, 1'b1)];
                net_crd_ret[c] <= gnt[vc_index(c, 1'b0)];
            end
        end
    end

    assert_credit_per_flit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({loc_crd_ret, net_crd_ret}) == 32'(out_vld));
    assert_credit_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (loc_crd_ret[out_cls] || net_crd_ret[out_cls]));
    assert_no_interleave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_tail) |=> (!out_vld || out_cls == $past(out_cls)));
endmodule

// File: tb/rtn_merge_node_tb_top.sv
// Bench for rtn_merge_node: a table of single-flit vectors, then directed
// tests for reset, priority, credit starvation, FIFO depth and packet lock.
module rtn_merge_node_tb_top;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          loc_vld, loc_cls, loc_tail;
    logic [DW-1:0] loc_data;
    logic [1:0]    loc_crd_ret;
    logic          net_vld, net_cls, net_tail;
    logic [DW-1:0] net_data;
    logic [1:0]    net_crd_ret;
    logic          out_vld, out_cls, out_tail;
    logic [DW-1:0] out_data;
    logic [1:0]    out_crd_in;

    int   nchk  = 0;
    int   nfail = 0;
    bit   auto_ret;
    logic [1:0] man_crd;

    always #5 clk = ~clk;

    rtn_merge_node dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_vld(loc_vld), .loc_cls(loc_cls), .loc_tail(loc_tail),
        .loc_data(loc_data), .loc_crd_ret(loc_crd_ret),
        .net_vld(net_vld), .net_cls(net_cls), .net_tail(net_tail),
        .net_data(net_data), .net_crd_ret(net_crd_ret),
        .out_vld(out_vld), .out_cls(out_cls), .out_tail(out_tail),
        .out_data(out_data), .out_crd_in(out_crd_in)
    );

    // Vector fields: {port is network, class, tag}.
    localparam logic [17:0] VECS [8] = '{
        {1'b0, 1'b0, 16'h1100}, {1'b0, 1'b1, 16'h1201},
        {1'b1, 1'b0, 16'h2302}, {1'b1, 1'b1, 16'h2403},
        {1'b1, 1'b0, 16'hFFFF}, {1'b0, 1'b1, 16'h0000},
        {1'b0, 1'b0, 16'h5A5A}, {1'b1, 1'b1, 16'hA5A5}
    };

    function automatic logic [DW-1:0] pat(input logic [15:0] t);
        return {8{t}};
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Advance one cycle, sample outputs mid-cycle and clear one-shot inputs.
    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        loc_vld = 1'b0;
        net_vld = 1'b0;
        out_crd_in = man_crd |
            ((auto_ret && out_vld) ? (out_cls ? 2'b10 : 2'b01) : 2'b00);
    endtask

    task automatic drv(input bit is_net, input logic cls, input logic tl,
                       input logic [15:0] tag);
        if (is_net) begin
            net_vld = 1'b1; net_cls = cls; net_tail = tl; net_data = pat(tag);
        end else begin
            loc_vld = 1'b1; loc_cls = cls; loc_tail = tl; loc_data = pat(tag);
        end
    endtask

    task automatic apply_reset;
        rst_n = 1'b0;
        loc_vld = 0; loc_cls = 0; loc_tail = 0; loc_data = '0;
        net_vld = 0; net_cls = 0; net_tail = 0; net_data = '0;
        man_crd = 2'b00; out_crd_in = 2'b00; auto_ret = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_flit(input string rq, input logic cls,
                               input logic [15:0] tag, input bit is_net);
        logic [1:0] bitv;
        bitv = cls ? 2'b10 : 2'b01;
        chk(rq, "out_vld", DW'(out_vld), DW'(1));
        chk(rq, "out_cls", DW'(out_cls), DW'(cls));
        chk(rq, "out_data", out_data, pat(tag));
        chk("R7", "loc_crd_ret", DW'(loc_crd_ret), DW'(is_net ? 2'b00 : bitv));
        chk("R7", "net_crd_ret", DW'(net_crd_ret), DW'(is_net ? bitv : 2'b00));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        apply_reset();
        // R1: idle outputs after reset.
        chk("R1", "out_vld", DW'(out_vld), DW'(0));
        chk("R1", "crd_ret", DW'({loc_crd_ret, net_crd_ret}), DW'(0));

        // Vector table: single uncontended flits (R2, R3, R7).
        foreach (VECS[i]) begin
            drv(VECS[i][17], VECS[i][16], 1'b1, VECS[i][15:0]);
            tick();
            chk("R3", "no output on arrival cycle", DW'(out_vld), DW'(0));
            tick();
            expect_flit("R2", VECS[i][16], VECS[i][15:0], VECS[i][17]);
        end
        tick();

        // R4 priority: four VCs loaded over two cycles.
        drv(1'b1, 1'b1, 1'b1, 16'hA001);
        drv(1'b0, 1'b0, 1'b1, 16'hA002);
        tick();
        drv(1'b0, 1'b1, 1'b1, 16'hB001);
        drv(1'b1, 1'b0, 1'b1, 16'hB002);
        tick();
        expect_flit("R4", 1'b1, 16'hA001, 1'b1);
        tick();
        expect_flit("R4", 1'b1, 16'hB001, 1'b0);
        tick();
        expect_flit("R4", 1'b0, 16'hB002, 1'b1);
        tick();
        expect_flit("R4", 1'b0, 16'hA002, 1'b0);
        tick();
        chk("R9", "idle out_vld", DW'(out_vld), DW'(0));

        // Credit starvation, FIFO depth and order (R1, R5, R6, R10).
        apply_reset();
        auto_ret = 1'b0;
        for (int i = 0; i < 4; i++) begin
            drv(1'b0, 1'b0, 1'b1, 16'hC000 + 16'(i));
            tick();
            if (i > 0) expect_flit("R1", 1'b0, 16'hC000 + 16'(i - 1), 1'b0);
        end
        tick();
        expect_flit("R1", 1'b0, 16'hC003, 1'b0);
        for (int i = 4; i < 8; i++) begin
            drv(1'b0, 1'b0, 1'b1, 16'hC000 + 16'(i));
            tick();
            chk("R5", "no request credit", DW'(out_vld), DW'(0));
        end
        drv(1'b0, 1'b1, 1'b1, 16'hD00D);
        tick();
        chk("R5", "response queued", DW'(out_vld), DW'(0));
        tick();
        expect_flit("R5", 1'b1, 16'hD00D, 1'b0);
        man_crd = 2'b01;
        out_crd_in = 2'b01;
        tick();
        chk("R6", "credit lands this edge", DW'(out_vld), DW'(0));
        tick();
        expect_flit("R10", 1'b0, 16'hC004, 1'b0);
        tick();
        expect_flit("R10", 1'b0, 16'hC005, 1'b0);
        tick();
        expect_flit("R10", 1'b0, 16'hC006, 1'b0);
        man_crd = 2'b00;
        out_crd_in = 2'b00;
        tick();
        expect_flit("R6", 1'b0, 16'hC007, 1'b0);
        tick();
        chk("R9", "credits spent again", DW'(out_vld), DW'(0));

        // R8: three-flit local request packet holds off a network response.
        apply_reset();
        drv(1'b0, 1'b0, 1'b0, 16'hE000);
        tick();
        drv(1'b0, 1'b0, 1'b0, 16'hE001);
        drv(1'b1, 1'b1, 1'b1, 16'hF00F);
        tick();
        expect_flit("R8", 1'b0, 16'hE000, 1'b0);
        chk("R8", "head tail bit", DW'(out_tail), DW'(0));
        drv(1'b0, 1'b0, 1'b1, 16'hE002);
        tick();
        expect_flit("R8", 1'b0, 16'hE001, 1'b0);
        tick();
        expect_flit("R8", 1'b0, 16'hE002, 1'b0);
        chk("R8", "tail bit", DW'(out_tail), DW'(1));
        tick();
        expect_flit("R8", 1'b1, 16'hF00F, 1'b1);
        tick();
        chk("R9", "drained", DW'(out_vld), DW'(0));

        summary();
        $finish;
    end
endmodule